// File: doc/BRIEF.md
# Interrupt and Reset Entry Sequencer

This block runs the bus cycles that take an 8-bit processor into a service routine. It handles four causes: reset, a non-maskable request, a maskable request and a software break. At an instruction boundary the core presents its program counter, status byte and stack pointer. The sequencer then owns the bus for seven cycles. It makes two dummy reads at the saved PC. It then pushes the return state into the stack page, downward from 0x0100 + S, and reads a 16-bit little-endian vector. One cycle later it hands back the new PC, stack pointer and status.

The memory answers combinationally: `rdata` is the byte at `addr` in the same cycle. A reset cause performs the same seven cycles without writing, and starts the stack pointer at 0xFF. A break pushes PC+2 and tags only the pushed status copy. A hardware request that is present when a break is strobed takes over the entry, and the break is dropped.

Top module: `irq_entry_seq`

## Requirements
- R1: After `rst_n` is released the block runs a reset entry of 7 busy cycles. It makes no write, reads 0xFFFC then 0xFFFD, and ends with `pc_out` = {byte at 0xFFFD, byte at 0xFFFC}, `sp_out` = 0xFF and `status_out` = 0x24. While `rst_n` is low, `we` is 0.
- R2: A non-reset entry writes exactly three bytes, in this order: PC high to 0x0100+S, PC low to 0x0100+S-1, status to 0x0100+S-2. The low address byte wraps within the page, and `sp_out` = S-3 modulo 256.
- R3: A non-maskable request is taken on a rising edge of `nmi`, is remembered until serviced even if `nmi` falls first, and uses the vector at 0xFFFA/0xFFFB. A level held high causes only one entry.
- R4: A maskable request (`irq` high) is taken only while `status_in` bit 2 (I) is 0, and uses the vector at 0xFFFE/0xFFFF.
- R5: A break (`brk_op` strobe) is taken regardless of I, pushes `pc_in`+2 (carry into the high byte included), uses 0xFFFE/0xFFFF, and writes bit 4 = 1 in the pushed status.
- R6: The pushed status always has bit 5 = 1. Bit 4 is 0 in it for every cause except break.
- R7: After any entry, `status_out` equals the entry `status_in` with bit 2 set, bit 5 set and bit 4 cleared. Bits 7, 6, 3, 1 and 0, including the decimal flag in bit 3, are unchanged.
- R8: If a break is strobed while an enabled hardware request is present, only the hardware entry happens: PC is pushed without +2, bit 4 of the pushed status is 0, and the hardware vector is used.
- R9: A pending non-maskable request wins over a maskable request presented at the same boundary.
- R10: Every entry keeps `busy` high for exactly 7 cycles, writes only while `busy` is high, then pulses `done` for one cycle.
- R11: No entry starts while `at_boundary` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; release starts the reset entry |
| at_boundary | input | 1 | Core is between instructions and may be interrupted |
| nmi | input | 1 | Non-maskable request, rising-edge sensitive |
| irq | input | 1 | Maskable request, level sensitive |
| brk_op | input | 1 | Break opcode decoded at this boundary |
| pc_in | input | 16 | Core program counter (address of the break opcode for a break) |
| status_in | input | 8 | Core status byte; bit 2 is the interrupt-disable flag |
| sp_in | input | 8 | Core stack pointer |
| rdata | input | 8 | Memory read data for the current address |
| addr | output | 16 | Bus address |
| wdata | output | 8 | Bus write data |
| we | output | 1 | Write enable |
| busy | output | 1 | Entry sequence owns the bus |
| done | output | 1 | One-cycle pulse: pc_out, sp_out and status_out are updated |
| pc_out | output | 16 | Loaded vector |
| sp_out | output | 8 | Stack pointer after the entry |
| status_out | output | 8 | Status after the entry |

## Verification
The bench targets the break-versus-hardware collision. A design that kept the break would push PC+2 and a tagged status, or would read the wrong vector. The bench places a break at a PC ending in 0xFF and a stack pointer near 0x01. A design with a missing carry pushes the wrong high byte, and one with a missing page wrap writes outside the stack page. It holds `nmi` high across an entry and pulses it while the core is not at a boundary. A level-sensitive design re-enters repeatedly; a design without the latch loses the request. It also checks that the decimal flag survives entry and that a masked `irq` starts nothing.

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter logic [15:0] VEC_NMI    = 16'hFFFA,
  parameter logic [15:0] VEC_RST    = 16'hFFFC,
  parameter logic [15:0] VEC_IRQ    = 16'hFFFE,
  parameter logic [7:0]  STACK_PAGE = 8'h01,
  parameter logic [7:0]  SP_INIT    = 8'hFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        at_boundary,
  input  logic        nmi,
  input  logic        irq,
  input  logic        brk_op,
  input  logic [15:0] pc_in,
  input  logic [7:0]  status_in,
  input  logic [7:0]  sp_in,
  input  logic [7:0]  rdata,
  output logic [15:0] addr,
  output logic [7:0]  wdata,
  output logic        we,
  output logic        busy,
  output logic        done,
  output logic [15:0] pc_out,
  output logic [7:0]  sp_out,
  output logic [7:0]  status_out
);
  typedef enum logic [3:0] {IDLE, DUMMY0, DUMMY1, PUSH_H, PUSH_L, PUSH_P, VEC_L, VEC_H, FIN} st_t;
  localparam logic [1:0] K_RST = 2'd0, K_NMI = 2'd1, K_IRQ = 2'd2, K_BRK = 2'd3;

  st_t         state;
  logic [1:0]  kind;
  logic [15:0] pc_save;
  logic [7:0]  p_save, sp_w, vec_lo;
  logic        nmi_q, nmi_pend;

  logic        hw_irq, accept, is_rst, push;
  logic [1:0]  sel_kind;
  logic [15:0] vec_base;

  assign hw_irq   = irq & ~status_in[2];
  assign accept   = (state == IDLE) & at_boundary & (nmi_pend | hw_irq | brk_op);
  assign sel_kind = nmi_pend ? K_NMI : (hw_irq ? K_IRQ : K_BRK);
  assign is_rst   = (kind == K_RST);
  assign push     = (state == PUSH_H) | (state == PUSH_L) | (state == PUSH_P);
  assign we       = push & ~is_rst;
  assign busy     = (state != IDLE) & (state != FIN);
  assign done     = (state == FIN);
  assign vec_base = (kind == K_NMI) ? VEC_NMI : (is_rst ? VEC_RST : VEC_IRQ);

  always_comb begin
    case (state)
      DUMMY1:                 addr = pc_save + 16'd1;
      PUSH_H, PUSH_L, PUSH_P: addr = {STACK_PAGE, sp_w};
      VEC_L:                  addr = vec_base;
      VEC_H:                  addr = vec_base + 16'd1;
      default:                addr = pc_save;
    endcase
    case (state)
      PUSH_H:  wdata = pc_save[15:8];
      PUSH_L:  wdata = pc_save[7:0];
      PUSH_P:  wdata = {p_save[7:6], 1'b1, kind == K_BRK, p_save[3:0]};
      default: wdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_q    <= 1'b0;
      nmi_pend <= 1'b0;
    end else begin
      nmi_q    <= nmi;
      nmi_pend <= (nmi_pend & ~(accept & (sel_kind == K_NMI))) | (nmi & ~nmi_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= DUMMY0;
      kind       <= K_RST;
      pc_save    <= '0;
      p_save     <= '0;
      sp_w       <= SP_INIT;
      vec_lo     <= '0;
      pc_out     <= '0;
      sp_out     <= SP_INIT;
      status_out <= 8'h24;
    end else begin
      case (state)
        IDLE: if (accept) begin
          state   <= DUMMY0;
          kind    <= sel_kind;
          pc_save <= (sel_kind == K_BRK) ? pc_in + 16'd2 : pc_in;
          p_save  <= status_in;
          sp_w    <= sp_in;
        end
        DUMMY0: state <= DUMMY1;
        DUMMY1: state <= PUSH_H;
        PUSH_H, PUSH_L, PUSH_P: begin
          state <= (state == PUSH_H) ? PUSH_L : ((state == PUSH_L) ? PUSH_P : VEC_L);
          if (!is_rst) sp_w <= sp_w - 8'd1;
        end
        VEC_L: begin
          vec_lo <= rdata;
          state  <= VEC_H;
        end
        VEC_H: begin
          pc_out     <= {rdata, vec_lo};
          sp_out     <= sp_w;
          status_out <= {p_save[7:6], 1'b1, 1'b0, p_save[3], 1'b1, p_save[1:0]};
          state      <= FIN;
        end
        default: state <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        we,
  input logic        busy,
  input logic        done,
  input logic [15:0] addr,
  input logic [7:0]  wdata
);
  a_r2_push_in_stack_page: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> addr[15:8] == 8'h01);
  a_r2_push_descends: assert property (@(posedge clk) disable iff (!rst_n)
    (we && $past(we)) |-> addr[7:0] == $past(addr[7:0]) - 8'd1);
  a_r6_status_bit5: assert property (@(posedge clk) disable iff (!rst_n)
    (we && $past(we) && $past(we, 2)) |-> wdata[5]);
  a_r10_write_inside_entry: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> busy);
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_done_follows_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));
endmodule

bind irq_entry_seq irq_entry_chk u_chk (
  .clk(clk), .rst_n(rst_n), .we(we), .busy(busy), .done(done), .addr(addr), .wdata(wdata)
);

// File: tb/tb_irq_entry_seq.sv
module tb_irq_entry_seq;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        at_boundary = 1'b0, nmi = 1'b0, irq = 1'b0, brk_op = 1'b0;
  logic [15:0] pc_in = '0;
  logic [7:0]  status_in = '0, sp_in = '0, rdata;
  logic [15:0] addr, pc_out;
  logic [7:0]  wdata, sp_out, status_out;
  logic        we, busy, done;

  irq_entry_seq dut (
    .clk(clk), .rst_n(rst_n), .at_boundary(at_boundary), .nmi(nmi), .irq(irq), .brk_op(brk_op),
    .pc_in(pc_in), .status_in(status_in), .sp_in(sp_in), .rdata(rdata),
    .addr(addr), .wdata(wdata), .we(we), .busy(busy), .done(done),
    .pc_out(pc_out), .sp_out(sp_out), .status_out(status_out)
  );

  always #2 clk = ~clk;

  function automatic logic [7:0] mem(input logic [15:0] a);
    case (a)
      16'hFFFA: mem = 8'h34;
      16'hFFFB: mem = 8'h56;
      16'hFFFC: mem = 8'h00;
      16'hFFFD: mem = 8'h80;
      16'hFFFE: mem = 8'h78;
      16'hFFFF: mem = 8'h9A;
      default:  mem = 8'hEA;
    endcase
  endfunction
  assign rdata = mem(addr);

  int checks = 0, errs = 0;
  int cyc = 0, nw = 0, nr = 0;
  logic [15:0] wr_a [4];
  logic [7:0]  wr_d [4];
  logic [15:0] rd_a [4];

  always begin
    @(negedge clk);
    #1;
    if (rst_n) begin
      if (busy) cyc++;
      if (we) begin
        if (nw < 4) begin wr_a[nw] = addr; wr_d[nw] = wdata; end
        nw++;
      end else if (busy && addr[15:8] == 8'hFF) begin
        if (nr < 4) rd_a[nr] = addr;
        nr++;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    cyc = 0; nw = 0; nr = 0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 30 && !done; i++) begin @(negedge clk); #2; end
    @(negedge clk); #2;
  endtask

  task automatic run_entry();
    clear_mon();
    at_boundary = 1'b1;
    for (int i = 0; i < 8 && !busy; i++) begin @(negedge clk); #2; end
    at_boundary = 1'b0;
    brk_op = 1'b0;
    wait_done();
  endtask

  task automatic verify(input string req, input logic [15:0] a0, input logic [7:0] d0,
                        input logic [15:0] a1, input logic [7:0] d1,
                        input logic [15:0] a2, input logic [7:0] d2,
                        input logic [15:0] vec, input logic [15:0] pc,
                        input logic [7:0] sp, input logic [7:0] st);
    check({req, " R10 busy cycles"}, cyc, 7);
    check({req, " R2 write count"}, nw, 3);
    check({req, " R2 push hi addr"}, wr_a[0], a0);
    check({req, " R2 push hi data"}, wr_d[0], d0);
    check({req, " R2 push lo addr"}, wr_a[1], a1);
    check({req, " R2 push lo data"}, wr_d[1], d1);
    check({req, " R2 push status addr"}, wr_a[2], a2);
    check({req, " R6 push status data"}, wr_d[2], d2);
    check({req, " vector reads"}, nr, 2);
    check({req, " vector low addr"}, rd_a[0], vec);
    check({req, " vector high addr"}, rd_a[1], vec + 16'd1);
    check({req, " new pc"}, pc_out, pc);
    check({req, " R2 sp_out"}, sp_out, sp);
    check({req, " R7 status_out"}, status_out, st);
  endtask

  task automatic idle_window(input string req, input int n);
    clear_mon();
    at_boundary = 1'b1;
    repeat (n) @(negedge clk);
    #2;
    at_boundary = 1'b0;
    check({req, " no entry cycles"}, cyc, 0);
    check({req, " no writes"}, nw, 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    #2;
    check("R1 we low in reset", we, 0);
    clear_mon();
    @(negedge clk);
    rst_n = 1'b1;
    wait_done();
    check("R1 busy cycles", cyc, 7);
    check("R1 no writes", nw, 0);
    check("R1 vector reads", nr, 2);
    check("R1 vector low addr", rd_a[0], 16'hFFFC);
    check("R1 vector high addr", rd_a[1], 16'hFFFD);
    check("R1 pc", pc_out, 16'h8000);
    check("R1 sp", sp_out, 8'hFF);
    check("R1 status", status_out, 8'h24);
  endtask

  task automatic t_irq();
    pc_in = 16'h1234; status_in = 8'hC9; sp_in = 8'hFD; irq = 1'b1;
    run_entry();
    irq = 1'b0;
    verify("R4 irq", 16'h01FD, 8'h12, 16'h01FC, 8'h34, 16'h01FB, 8'hE9,
           16'hFFFE, 16'h9A78, 8'hFA, 8'hED);
  endtask

  task automatic t_irq_masked();
    status_in = 8'h04; irq = 1'b1;
    idle_window("R4 masked irq", 10);
    status_in = 8'h00;
    clear_mon();
    repeat (6) @(negedge clk);
    #2;
    check("R11 no entry without boundary", cyc, 0);
    irq = 1'b0;
  endtask

  task automatic t_brk();
    pc_in = 16'h30FF; status_in = 8'h0C; sp_in = 8'hFF; brk_op = 1'b1;
    run_entry();
    verify("R5 break", 16'h01FF, 8'h31, 16'h01FE, 8'h01, 16'h01FD, 8'h3C,
           16'hFFFE, 16'h9A78, 8'hFC, 8'h2C);
  endtask

  task automatic t_brk_irq();
    pc_in = 16'h4000; status_in = 8'h00; sp_in = 8'hF0; brk_op = 1'b1; irq = 1'b1;
    run_entry();
    irq = 1'b0;
    verify("R8 break with irq", 16'h01F0, 8'h40, 16'h01EF, 8'h00, 16'h01EE, 8'h20,
           16'hFFFE, 16'h9A78, 8'hED, 8'h24);
  endtask

  task automatic t_nmi_latched();
    nmi = 1'b1;
    @(negedge clk);
    nmi = 1'b0;
    @(negedge clk);
    pc_in = 16'h2000; status_in = 8'h00; sp_in = 8'h01;
    run_entry();
    verify("R3 latched nmi", 16'h0101, 8'h20, 16'h0100, 8'h00, 16'h01FF, 8'h20,
           16'hFFFA, 16'h5634, 8'hFE, 8'h24);
  endtask

  task automatic t_nmi_held();
    nmi = 1'b1;
    pc_in = 16'h2100; status_in = 8'hC3; sp_in = 8'h80;
    run_entry();
    verify("R3 held nmi", 16'h0180, 8'h21, 16'h017F, 8'h00, 16'h017E, 8'hE3,
           16'hFFFA, 16'h5634, 8'h7D, 8'hE7);
    idle_window("R3 held level no reentry", 10);
    nmi = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_nmi_irq();
    nmi = 1'b1;
    @(negedge clk);
    pc_in = 16'h5000; status_in = 8'h00; sp_in = 8'h40; irq = 1'b1;
    run_entry();
    irq = 1'b0; nmi = 1'b0;
    verify("R9 nmi over irq", 16'h0140, 8'h50, 16'h013F, 8'h00, 16'h013E, 8'h20,
           16'hFFFA, 16'h5634, 8'h3D, 8'h24);
    @(negedge clk);
  endtask

  task automatic t_nmi_brk();
    nmi = 1'b1;
    @(negedge clk);
    pc_in = 16'h6000; status_in = 8'h01; sp_in = 8'h20; brk_op = 1'b1;
    run_entry();
    nmi = 1'b0;
    verify("R8 break with nmi", 16'h0120, 8'h60, 16'h011F, 8'h00, 16'h011E, 8'h21,
           16'hFFFA, 16'h5634, 8'h1D, 8'h25);
  endtask

  initial begin
    t_reset();
    t_irq();
    t_irq_masked();
    t_brk();
    t_brk_irq();
    t_nmi_latched();
    t_nmi_held();
    t_nmi_irq();
    t_nmi_brk();
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errs++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule